// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog built around a 12-bit down-counter. The counter moves one step per pulse on a slow tick-enable input, which the chip supplies at 256 Hz. A timeout of s seconds is programmed as s*256-1, so the longest period is 4096 ticks, or 16 seconds. Software keeps the system alive by writing a restart command that carries a password byte. That restart is honoured only while the counter has fallen to or below a programmed window value. A restart that comes too early counts as a fault, just as a counter that runs out does.

The configuration word can be written once after a system reset and is then locked. It holds the reload value, the window value and a set of single-bit controls:
- a reset request enable;
- a choice between a whole-system reset and a processor-only reset;
- an interrupt enable;
- a disable bit;
- two halt controls that freeze counting while a debug-halt or idle input is high.

Faults are recorded in two clear-on-read status flags. The current counter value can be read through the same status word.

Top module: `winwdt`

## Requirements
- R1: After reset the mode word (offset 0x04) reads 0x0FFF2FFF: reload 0xFFF, window 0xFFF, reset enable set, all other controls clear, unlocked. The counter starts at 0xFFF, and the status word reads 0x0FFF0000.
- R2: A write to offset 0x00 is a restart command only if bit 0 is 1 and bits 31:24 hold 0xA5. Any other write to 0x00 leaves the counter and the flags unchanged.
- R3: Each tick-enable pulse lowers the counter by one. A pulse that arrives while the counter is 0 is an underflow: it sets status bit 0 and reloads the counter from the reload field.
- R4: The mode word at 0x04 is laid out as reload in bits 11:0, interrupt enable in bit 12, reset enable in bit 13, processor-only reset in bit 14, disable in bit 15, window in bits 27:16, debug-halt enable in bit 28 and idle-halt enable in bit 29. The first write after reset stores it and loads the counter with the new reload value. Every later write is ignored until the next reset.
- R5: A restart command while the counter is at or below the window value reloads the counter from the reload field. A window of 0xFFF therefore allows a restart at any count.
- R6: A restart command while the counter is above the window value is an error. It sets status bit 1 and leaves the counter unchanged.
- R7: When reset enable is set, an underflow or error raises a reset request until the next tick-enable pulse. The request goes on cpu_rst_req if bit 14 is set, and on sys_rst_req otherwise. fault_irq is high while interrupt enable is set and either status flag is set.
- R8: With the disable bit set, the counter holds its value, restart commands are ignored, and no flag, reset request or interrupt is produced.
- R9: Tick pulses are ignored while dbg_halt is high and bit 28 is set, or while idle_halt is high and bit 29 is set. With those bits clear, the halt inputs have no effect.
- R10: The status word at offset 0x08 returns the underflow flag in bit 0, the error flag in bit 1 and the counter in bits 27:16. A read clears both flags, but a fault in the same cycle as the read leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle counting pulse at 256 Hz |
| dbg_halt | input | 1 | Processor in debug halt |
| idle_halt | input | 1 | Processor in idle state |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on 0x08) |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| sys_rst_req | output | 1 | Whole-system reset request |
| cpu_rst_req | output | 1 | Processor-only reset request |
| fault_irq | output | 1 | Watchdog fault interrupt |

## Verification
An underflow tick and a status read can fall in the same clock cycle, and then the flag clear and the flag set compete for the same register. The bench drives the tick pulse and the status read together in the cycle where the counter sits at zero. It expects the read to return the old, empty flags. It then expects a second read to show the underflow flag still set and the counter reloaded, with the reset request and the interrupt both raised. A window error raised by a restart write cannot coincide with a read, because the port carries only one access per cycle.

// File: rtl/winwdt_pkg.sv
// Package: shared widths, register offsets, the restart key and the mode
// word type used by the windowed watchdog. Field positions are fixed by the
// register layout, not by the width parameters.
package winwdt_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MODE = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

    localparam logic [7:0] RESTART_KEY = 8'hA5;

    typedef struct packed {
        logic             idle_hlt_en;
        logic             dbg_hlt_en;
        logic [CNT_W-1:0] window;
        logic             dis;
        logic             proc_only;
        logic             rst_en;
        logic             irq_en;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam mode_t MODE_DFLT = '{
        idle_hlt_en: 1'b0, dbg_hlt_en: 1'b0, window: '1, dis: 1'b0,
        proc_only: 1'b0, rst_en: 1'b1, irq_en: 1'b0, reload: '1
    };

    // Unpack a bus word into the mode fields.
    function automatic mode_t word2mode(input logic [DATA_W-1:0] w);
        mode_t m;
        m.reload      = w[11:0];
        m.irq_en      = w[12];
        m.rst_en      = w[13];
        m.proc_only   = w[14];
        m.dis         = w[15];
        m.window      = w[27:16];
        m.dbg_hlt_en  = w[28];
        m.idle_hlt_en = w[29];
        return m;
    endfunction

    // Pack the mode fields into a bus word.
    function automatic logic [DATA_W-1:0] mode2word(input mode_t m);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[11:0]  = m.reload;
        w[12]    = m.irq_en;
        w[13]    = m.rst_en;
        w[14]    = m.proc_only;
        w[15]    = m.dis;
        w[27:16] = m.window;
        w[28]    = m.dbg_hlt_en;
        w[29]    = m.idle_hlt_en;
        return w;
    endfunction

endpackage

// File: rtl/winwdt_regs.sv
// Register file: decodes the restart command and the write-once mode
// register, holds the clear-on-read fault flags and drives read data.
// Assumes one access per cycle and read data sampled in the rd_en cycle.
module winwdt_regs
    import winwdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          unf_evt,
    input  logic          err_evt,
    input  logic [CW-1:0] cnt,
    output mode_t         mode_q,
    output logic          locked_q,
    output logic          mode_wr,
    output logic          restart_req,
    output logic          unf_flag,
    output logic          err_flag,
    output logic [DW-1:0] rdata
);

    localparam int KEY_LSB = DW - 8;
    localparam int CNT_LSB = 16;

    logic stat_rd;

    // Command decode: keyed restart, first mode write, status read.
    always_comb begin
        restart_req = wr_en && (addr == OFS_CTRL) && wdata[0]
                      && (wdata[DW-1:KEY_LSB] == RESTART_KEY);
        mode_wr     = wr_en && (addr == OFS_MODE) && !locked_q;
        stat_rd     = rd_en && (addr == OFS_STAT);
    end

    // Mode register with its write-once lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_DFLT;
            locked_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q   <= word2mode(wdata);
            locked_q <= 1'b1;
        end
    end

    // Fault flags: a new event wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unf_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            unf_flag <= unf_evt || (unf_flag && !stat_rd);
            err_flag <= err_evt || (err_flag && !stat_rd);
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == OFS_MODE) begin
                rdata = mode2word(mode_q);
            end else if (addr == OFS_STAT) begin
                rdata[0] = unf_flag;
                rdata[1] = err_flag;
                rdata[CNT_LSB +: CW] = cnt;
            end
        end
    end

endmodule

// File: rtl/winwdt_count.sv
// Counter core: steps the down-counter on qualified ticks, checks restart
// commands against the window and reports underflow and window errors.
// Assumes tick_en is a one-cycle pulse from the slow clock domain.
module winwdt_count
    import winwdt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          dbg_halt,
    input  logic          idle_halt,
    input  logic          dbg_hlt_en,
    input  logic          idle_hlt_en,
    input  logic          dis,
    input  logic [CW-1:0] reload,
    input  logic [CW-1:0] window,
    input  logic          mode_wr,
    input  logic [CW-1:0] new_reload,
    input  logic          restart_req,
    output logic [CW-1:0] cnt_q,
    output logic          restart_ok,
    output logic          unf_evt,
    output logic          err_evt
);

    logic halted;
    logic step;
    logic in_win;

    // Tick qualification and window test.
    always_comb begin
        halted     = (dbg_hlt_en && dbg_halt) || (idle_hlt_en && idle_halt);
        step       = tick_en && !halted && !dis;
        in_win     = (cnt_q <= window);
        restart_ok = restart_req && !dis && in_win;
        err_evt    = restart_req && !dis && !in_win;
        unf_evt    = step && (cnt_q == '0);
    end

    // Counter: mode load, then restart, then tick step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (mode_wr) begin
            cnt_q <= new_reload;
        end else if (restart_ok) begin
            cnt_q <= reload;
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/winwdt_fault.sv
// Fault outputs: stretches a reset request to the next tick, routes it to
// the system or processor reset, and forms the level interrupt.
module winwdt_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic fault_evt,
    input  logic rst_en,
    input  logic proc_only,
    input  logic irq_en,
    input  logic unf_flag,
    input  logic err_flag,
    output logic sys_rst_req,
    output logic cpu_rst_req,
    output logic fault_irq
);

    logic pend_q;

    // Reset request held from the fault until the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (fault_evt && rst_en) begin
            pend_q <= 1'b1;
        end else if (tick_en) begin
            pend_q <= 1'b0;
        end
    end

    // Output routing.
    always_comb begin
        sys_rst_req = pend_q && !proc_only;
        cpu_rst_req = pend_q && proc_only;
        fault_irq   = irq_en && (unf_flag || err_flag);
    end

endmodule

// File: rtl/winwdt.sv
// Top: windowed watchdog with keyed restart, write-once mode register,
// clear-on-read status and reset/interrupt outputs.
module winwdt
    import winwdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          dbg_halt,
    input  logic          idle_halt,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          sys_rst_req,
    output logic          cpu_rst_req,
    output logic          fault_irq
);

    mode_t         mode_q;
    logic          locked_q;
    logic          mode_wr;
    logic          restart_req;
    logic          restart_ok;
    logic          unf_flag;
    logic          err_flag;
    logic          unf_evt;
    logic          err_evt;
    logic          fault_evt;
    logic [CW-1:0] cnt_q;

    // Any fault event.
    always_comb fault_evt = unf_evt || err_evt;

    winwdt_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .unf_evt     (unf_evt),
        .err_evt     (err_evt),
        .cnt         (cnt_q),
        .mode_q      (mode_q),
        .locked_q    (locked_q),
        .mode_wr     (mode_wr),
        .restart_req (restart_req),
        .unf_flag    (unf_flag),
        .err_flag    (err_flag),
        .rdata       (rdata)
    );

    winwdt_count #(.CW(CW)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .dbg_halt    (dbg_halt),
        .idle_halt   (idle_halt),
        .dbg_hlt_en  (mode_q.dbg_hlt_en),
        .idle_hlt_en (mode_q.idle_hlt_en),
        .dis         (mode_q.dis),
        .reload      (mode_q.reload),
        .window      (mode_q.window),
        .mode_wr     (mode_wr),
        .new_reload  (wdata[CW-1:0]),
        .restart_req (restart_req),
        .cnt_q       (cnt_q),
        .restart_ok  (restart_ok),
        .unf_evt     (unf_evt),
        .err_evt     (err_evt)
    );

    winwdt_fault u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .fault_evt   (fault_evt),
        .rst_en      (mode_q.rst_en),
        .proc_only   (mode_q.proc_only),
        .irq_en      (mode_q.irq_en),
        .unf_flag    (unf_flag),
        .err_flag    (err_flag),
        .sys_rst_req (sys_rst_req),
        .cpu_rst_req (cpu_rst_req),
        .fault_irq   (fault_irq)
    );

endmodule

// File: rtl/winwdt_chk.sv
// Checker: temporal properties of the watchdog, bound to the top module.
module winwdt_chk
    import winwdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             dbg_halt,
    input logic             sys_rst_req,
    input logic             cpu_rst_req,
    input logic             fault_evt,
    input logic             locked_q,
    input mode_t            mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             restart_ok,
    input logic             mode_wr
);

    // R4: a locked mode register never changes.
    p_mode_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

    // R3: the counter never exceeds the reload value.
    p_cnt_le_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= mode_q.reload);

    // R7: a reset request lasts only to the next tick without a new fault.
    p_rst_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sys_rst_req || cpu_rst_req) && tick_en && !fault_evt)
        |=> !(sys_rst_req || cpu_rst_req));

    // R7: only one reset destination at a time.
    p_rst_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst_req && cpu_rst_req));

    // R8: a locked, disabled watchdog holds its counter.
    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && mode_q.dis) |=> $stable(cnt_q));

    // R9: a debug-halted tick does not move the counter.
    p_dbg_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && mode_q.dbg_hlt_en && dbg_halt && !restart_ok && !mode_wr)
        |=> $stable(cnt_q));

endmodule

bind winwdt winwdt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .dbg_halt    (dbg_halt),
    .sys_rst_req (sys_rst_req),
    .cpu_rst_req (cpu_rst_req),
    .fault_evt   (fault_evt),
    .locked_q    (locked_q),
    .mode_q      (mode_q),
    .cnt_q       (cnt_q),
    .restart_ok  (restart_ok),
    .mode_wr     (mode_wr)
);

// File: tb/winwdt_tb.sv
// Bench for winwdt: a vector table of restart scenarios, then directed tests.
module winwdt_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        idle_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_rst_req;
    logic        cpu_rst_req;
    logic        fault_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    winwdt u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .idle_halt(idle_halt), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req),
        .cpu_rst_req(cpu_rst_req), .fault_irq(fault_irq)
    );

    typedef struct packed {
        logic [11:0] reload;
        logic [11:0] window;
        logic [11:0] nticks;
        logic [7:0]  key;
        logic        go;
        logic [11:0] exp_cnt;
        logic        exp_err;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{12'h100, 12'hFFF, 12'd10, 8'hA5, 1'b1, 12'h100, 1'b0}, // R5 open window
        '{12'h100, 12'h0F0, 12'd10, 8'hA5, 1'b1, 12'h0F6, 1'b1}, // R6 too early
        '{12'h100, 12'h0F0, 12'd16, 8'hA5, 1'b1, 12'h100, 1'b0}, // R5 at window edge
        '{12'h100, 12'hFFF, 12'd10, 8'h5A, 1'b1, 12'h0F6, 1'b0}, // R2 bad key
        '{12'h100, 12'hFFF, 12'd10, 8'hA5, 1'b0, 12'h0F6, 1'b0}, // R2 bit 0 clear
        '{12'h020, 12'h010, 12'd31, 8'hA5, 1'b1, 12'h020, 1'b0}  // R5 low count
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        dbg_halt = 1'b0; idle_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    logic [31:0] v;

    initial begin
        do_reset();

        // Vector table: restart key and window qualification.
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            bus_wr(4'h4, {4'h0, VECS[i].window, 4'h2, VECS[i].reload});
            ticks(int'(VECS[i].nticks));
            bus_wr(4'h0, {VECS[i].key, 23'd0, VECS[i].go});
            bus_rd(4'h8, v);
            check($sformatf("R2/R5/R6 vec%0d counter", i), {20'd0, v[27:16]}, {20'd0, VECS[i].exp_cnt});
            check($sformatf("R6 vec%0d error flag", i), {31'd0, v[1]}, {31'd0, VECS[i].exp_err});
        end

        // R1: reset state.
        do_reset();
        bus_rd(4'h4, v);
        check("R1 mode default", v, 32'h0FFF2FFF);
        bus_rd(4'h8, v);
        check("R1 status default", v, 32'h0FFF0000);
        check("R1 outputs idle", {29'd0, sys_rst_req, cpu_rst_req, fault_irq}, 32'd0);

        // R9: halt inputs ignored while the halt bits are clear.
        dbg_halt = 1'b1; idle_halt = 1'b1;
        ticks(1);
        dbg_halt = 1'b0; idle_halt = 1'b0;
        bus_rd(4'h8, v);
        check("R9 halt ignored when disabled", {20'd0, v[27:16]}, 32'h00000FFE);

        // R4: write-once mode register.
        do_reset();
        bus_wr(4'h4, 32'h00F02010);
        bus_rd(4'h4, v);
        check("R4 first mode write", v, 32'h00F02010);
        bus_rd(4'h8, v);
        check("R4 counter loaded", {20'd0, v[27:16]}, 32'h00000010);
        bus_wr(4'h4, 32'h0FFF0FFF);
        bus_rd(4'h4, v);
        check("R4 second write ignored", v, 32'h00F02010);

        // R3/R7/R10: underflow in the same cycle as a status read.
        do_reset();
        bus_wr(4'h4, 32'h0FFF3003);
        ticks(3);
        @(negedge clk); tick_en = 1'b1; rd_en = 1'b1; addr = 4'h8;
        #1 v = rdata;
        @(negedge clk); tick_en = 1'b0; rd_en = 1'b0;
        check("R10 read before underflow", v, 32'h00000000);
        check("R7 system reset raised", {31'd0, sys_rst_req}, 32'd1);
        check("R7 cpu reset quiet", {31'd0, cpu_rst_req}, 32'd0);
        check("R7 irq raised", {31'd0, fault_irq}, 32'd1);
        bus_rd(4'h8, v);
        check("R3 R10 underflow flag kept and reload", v, 32'h00030001);
        check("R10 irq drops after clear", {31'd0, fault_irq}, 32'd0);
        check("R7 reset held until tick", {31'd0, sys_rst_req}, 32'd1);
        ticks(1);
        check("R7 reset ends after one tick", {31'd0, sys_rst_req}, 32'd0);

        // R7: processor-only routing.
        do_reset();
        bus_wr(4'h4, 32'h0FFF6001);
        ticks(2);
        check("R7 cpu reset routed", {30'd0, sys_rst_req, cpu_rst_req}, 32'd1);
        check("R7 no irq without enable", {31'd0, fault_irq}, 32'd0);

        // R6/R7: early restart raises the interrupt only.
        do_reset();
        bus_wr(4'h4, 32'h00101100);
        bus_wr(4'h0, 32'hA5000001);
        check("R7 error irq", {31'd0, fault_irq}, 32'd1);
        check("R7 no reset without enable", {31'd0, sys_rst_req}, 32'd0);
        bus_rd(4'h8, v);
        check("R6 error status", v, 32'h01000002);

        // R8: disabled watchdog.
        do_reset();
        bus_wr(4'h4, 32'h0FFFA005);
        ticks(10);
        bus_wr(4'h0, 32'hA5000001);
        bus_rd(4'h8, v);
        check("R8 counter frozen, no flags", v, 32'h00050000);
        check("R8 no reset", {30'd0, sys_rst_req, cpu_rst_req}, 32'd0);

        // R9: debug and idle halts.
        do_reset();
        bus_wr(4'h4, 32'h3FFF2010);
        dbg_halt = 1'b1;
        ticks(3);
        bus_rd(4'h8, v);
        check("R9 debug halt", {20'd0, v[27:16]}, 32'h00000010);
        dbg_halt = 1'b0; idle_halt = 1'b1;
        ticks(3);
        bus_rd(4'h8, v);
        check("R9 idle halt", {20'd0, v[27:16]}, 32'h00000010);
        idle_halt = 1'b0;
        ticks(2);
        bus_rd(4'h8, v);
        check("R3 R9 counting resumes", {20'd0, v[27:16]}, 32'h0000000E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule